// File: doc/BRIEF.md
# Flash Bus Operation Front End

This block is the pin-side front end of a parallel NOR-style flash memory. On every clock it classifies the active-low chip-enable, output-enable, write-enable and hardware-reset pins into a single bus operation. That operation is reset, standby, output-off, read, write, or a clash when write-enable and output-enable are both asserted. A small word-organised array model sits behind it. Reads return that array directly after reset, with no command sequence needed.

A byte-select pin chooses the data path width. With byte-select high, the full 16-bit word is driven. With byte-select low, only the lower byte lane is driven, and the top data pin becomes an extra low-order address input that picks one half of the stored word. Output enables come out per byte lane, so a pad ring or a bench can build the tri-state behaviour without tri-state primitives.

A write cycle captures the address and data into a command register. When write-enable or chip-enable deasserts, the block emits a single-cycle command strobe carrying the captured byte address and data for a downstream command interpreter. The block also leaves array-read mode at that point.

Top module: `nbf_bus_front`

## Requirements
- R1: With byte_n=1, ce_n=0, oe_n=0, we_n=1 and rst_n=1 in array-read mode, dq_out equals the array word at addr and both dq_oe_lo and dq_oe_hi are 1. The array word at index i is (i*0x0123 + 0x1357) mod 2^16.
- R2: With byte_n=0, the upper lane is never driven (dq_oe_hi=0 and dq_out[15:8]=0). On a read, dq_out[7:0] is the low byte of the selected word when dq_in[15]=0 and the high byte when dq_in[15]=1.
- R3: After rst_n returns high, the block is in array-read mode, and a read returns array data without any prior write.
- R4: A write (ce_n=0, we_n=0, oe_n=1) captures the address and data. In the cycle after the first clock edge at which the write is no longer active, cmd_valid is 1. cmd_addr is then {addr, 1'b0} in word mode or {addr, dq_in[15]} in byte mode. cmd_data is dq_in in word mode or {8'h00, dq_in[7:0]} in byte mode.
- R5: After a completed write, reads return the captured command data (steered by lane as in R1/R2) instead of array data, until the next reset.
- R6: With ce_n=1 (standby), or with oe_n=1 and we_n=1 (output off), neither lane output enable is asserted.
- R7: While rst_n=0, neither lane output enable is asserted, whatever the other pins are.
- R8: With ce_n=0, oe_n=0 and we_n=0, no lane is driven and no command strobe results.
- R9: bus_op encodes the operation as reset=4, standby=0, output-off=1, read=2, write=3, clash=5. The priority order is reset, then standby, then clash.
- R10: cmd_valid is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bus pins |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = word configuration, 0 = byte configuration |
| addr | input | AW | Word address |
| dq_in | input | DW | Data pins in; top pin is the low address bit in byte mode |
| dq_out | output | DW | Data pins out |
| dq_oe_lo | output | 1 | Drive enable for lower byte lane |
| dq_oe_hi | output | 1 | Drive enable for upper byte lane |
| bus_op | output | 3 | Decoded bus operation code |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | AW+1 | Captured byte address |
| cmd_data | output | DW | Captured command data |

## Verification
The only internal state is the array-read flag and the captured command. If the flag is wrong, the very next read shows command data where array data belongs, or array data where command data belongs. If the capture is wrong, the error shows at the strobe one cycle after the write ends. The lane enables and the steering are combinational from the pins, so a decode fault appears in the same cycle as the stimulus. The sweeps cover every address, both byte halves and all sixteen control pin combinations.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
   typedef enum logic [2:0] {
      OP_STANDBY = 3'd0,
      OP_OUT_OFF = 3'd1,
      OP_READ    = 3'd2,
      OP_WRITE   = 3'd3,
      OP_RESET   = 3'd4,
      OP_CLASH   = 3'd5
   } bus_op_e;
endpackage

// File: rtl/nbf_op_decode.sv
module nbf_op_decode
   import nbf_pkg::*;
(
   input  logic    rst_n,
   input  logic    ce_n,
   input  logic    oe_n,
   input  logic    we_n,
   output bus_op_e op
);
   always_comb begin
      if (!rst_n)                op = OP_RESET;
      else if (ce_n)             op = OP_STANDBY;
      else if (!oe_n && !we_n)   op = OP_CLASH;
      else if (!oe_n)            op = OP_READ;
      else if (!we_n)            op = OP_WRITE;
      else                       op = OP_OUT_OFF;
   end
endmodule

// File: rtl/nbf_word_rom.sv
module nbf_word_rom #(
   parameter int            AW  = 6,
   parameter int            DW  = 16,
   parameter logic [DW-1:0] MUL = 16'h0123,
   parameter logic [DW-1:0] ADD = 16'h1357
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] word
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [DW-1:0] VAL = DW'(i) * MUL + ADD;
      assign cells[i] = VAL;
   end

   assign word = cells[addr];
endmodule

// File: rtl/nbf_cmd_latch.sv
module nbf_cmd_latch #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          write_act,
   input  logic [AW:0]   byte_addr,
   input  logic [DW-1:0] wdata,
   output logic          cmd_valid,
   output logic [AW:0]   cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          array_mode
);
   logic wr_q;
   logic wr_end;

   assign wr_end = wr_q && !write_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q       <= 1'b0;
         cmd_valid  <= 1'b0;
         cmd_addr   <= '0;
         cmd_data   <= '0;
         array_mode <= 1'b1;
      end else begin
         wr_q      <= write_act;
         cmd_valid <= wr_end;
         if (write_act) begin
            cmd_addr <= byte_addr;
            cmd_data <= wdata;
         end
         if (wr_end) array_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/nbf_lane_steer.sv
module nbf_lane_steer #(
   parameter int DW = 16
) (
   input  logic          byte_mode,
   input  logic          lane_sel,
   input  logic          drive,
   input  logic [DW-1:0] src_word,
   output logic [DW-1:0] dq_out,
   output logic          oe_lo,
   output logic          oe_hi
);
   localparam int BW = DW / 2;

   logic [BW-1:0] picked;

   assign picked = lane_sel ? src_word[DW-1:BW] : src_word[BW-1:0];

   always_comb begin
      if (!drive)         dq_out = '0;
      else if (byte_mode) dq_out = {{BW{1'b0}}, picked};
      else                dq_out = src_word;
      oe_lo = drive;
      oe_hi = drive && !byte_mode;
   end
endmodule

// File: rtl/nbf_bus_front.sv
module nbf_bus_front
   import nbf_pkg::*;
#(
   parameter int            AW      = 6,
   parameter int            DW      = 16,
   parameter logic [DW-1:0] ROM_MUL = 16'h0123,
   parameter logic [DW-1:0] ROM_ADD = 16'h1357
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          byte_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe_lo,
   output logic          dq_oe_hi,
   output logic [2:0]    bus_op,
   output logic          cmd_valid,
   output logic [AW:0]   cmd_addr,
   output logic [DW-1:0] cmd_data
);
   localparam int BW = DW / 2;

   if (DW < 4 || (DW % 2) != 0) begin : g_bad_dw
      $error("nbf_bus_front: DW must be even and at least 4");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("nbf_bus_front: AW must lie in 1..12");
   end

   bus_op_e       op;
   logic          byte_mode;
   logic          lane_bit;
   logic [DW-1:0] rom_word;
   logic [DW-1:0] src_word;
   logic [DW-1:0] wdata;
   logic [AW:0]   byte_addr;
   logic          array_mode;

   assign byte_mode = !byte_n;
   assign lane_bit  = byte_mode && dq_in[DW-1];
   assign byte_addr = {addr, lane_bit};
   assign wdata     = byte_mode ? {{BW{1'b0}}, dq_in[BW-1:0]} : dq_in;
   assign bus_op    = op;

   nbf_op_decode u_dec (
      .rst_n (rst_n),
      .ce_n  (ce_n),
      .oe_n  (oe_n),
      .we_n  (we_n),
      .op    (op)
   );

   nbf_word_rom #(.AW(AW), .DW(DW), .MUL(ROM_MUL), .ADD(ROM_ADD)) u_rom (
      .addr (addr),
      .word (rom_word)
   );

   nbf_cmd_latch #(.AW(AW), .DW(DW)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .write_act  (op == OP_WRITE),
      .byte_addr  (byte_addr),
      .wdata      (wdata),
      .cmd_valid  (cmd_valid),
      .cmd_addr   (cmd_addr),
      .cmd_data   (cmd_data),
      .array_mode (array_mode)
   );

   assign src_word = array_mode ? rom_word : cmd_data;

   nbf_lane_steer #(.DW(DW)) u_steer (
      .byte_mode (byte_mode),
      .lane_sel  (lane_bit),
      .drive     (op == OP_READ),
      .src_word  (src_word),
      .dq_out    (dq_out),
      .oe_lo     (dq_oe_lo),
      .oe_hi     (dq_oe_hi)
   );
endmodule

// File: rtl/nbf_bus_front_chk.sv
module nbf_bus_front_chk #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          oe_n,
   input logic          we_n,
   input logic          byte_n,
   input logic [DW-1:0] dq_out,
   input logic          dq_oe_lo,
   input logic          dq_oe_hi,
   input logic [2:0]    bus_op,
   input logic          cmd_valid
);
   // R7: reset pin silences both lanes
   a_r7_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!dq_oe_lo && !dq_oe_hi && bus_op == 3'd4));

   // R6: standby or output-off drives nothing
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || (oe_n && we_n)) |-> (!dq_oe_lo && !dq_oe_hi));

   // R8: clash drives nothing
   a_r8_clash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && !we_n) |-> (!dq_oe_lo && !dq_oe_hi));

   // R2: byte mode leaves the upper lane undriven
   a_r2_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_n |-> (!dq_oe_hi && dq_out[DW-1:DW/2] == '0));

   // R10: strobe lasts one cycle
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R4: strobe only follows a write cycle
   a_r4_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(!ce_n && !we_n && oe_n, 2));
endmodule

bind nbf_bus_front nbf_bus_front_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .we_n      (we_n),
   .byte_n    (byte_n),
   .dq_out    (dq_out),
   .dq_oe_lo  (dq_oe_lo),
   .dq_oe_hi  (dq_oe_hi),
   .bus_op    (bus_op),
   .cmd_valid (cmd_valid)
);

// File: tb/nbf_bus_front_tb.sv
module nbf_bus_front_tb;
   localparam int AW = 6;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe_lo, dq_oe_hi, cmd_valid;
   logic [2:0]    bus_op;
   logic [AW:0]   cmd_addr;
   logic [DW-1:0] cmd_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nbf_bus_front #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .bus_op(bus_op),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   function automatic logic [15:0] rom_word(input int i);
      return 16'((i * 16'h0123 + 16'h1357) & 16'hFFFF);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pins(input logic c, input logic o, input logic w, input logic b);
      ce_n = c; oe_n = o; we_n = w; byte_n = b;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // reset state, R7 and R9
      step();
      pins(1'b0, 1'b0, 1'b1, 1'b1);
      #1;
      chk("R7 oe during reset", {dq_oe_lo, dq_oe_hi}, 2'b00);
      chk("R9 op during reset", bus_op, 3'd4);
      step();
      rst_n = 1'b1;

      // R3: read immediately after reset, no command
      step();
      addr = '0; #1;
      chk("R3 read after reset", dq_out, rom_word(0));

      // R1: every word address
      for (int i = 0; i < (1 << AW); i++) begin
         step();
         addr = AW'(i); #1;
         chk("R1 word data", dq_out, rom_word(i));
         chk("R1 both lanes", {dq_oe_lo, dq_oe_hi}, 2'b11);
      end

      // R2: every byte address
      pins(1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < (2 << AW); i++) begin
         step();
         addr = AW'(i >> 1);
         dq_in = {i[0], 15'h5AA5};
         #1;
         chk("R2 byte data", dq_out,
             {8'h00, (i[0] ? rom_word(i >> 1) >> 8 : rom_word(i >> 1)) & 16'h00FF});
         chk("R2 lanes", {dq_oe_lo, dq_oe_hi}, 2'b10);
      end

      // R6, R8, R9: all control pin combinations
      for (int k = 0; k < 16; k++) begin
         logic c, o, w, b;
         logic [2:0] eop;
         {c, o, w, b} = 4'(k);
         step();
         pins(c, o, w, b); addr = 6'd7; dq_in = 16'h0000;
         #1;
         if (c)           eop = 3'd0;
         else if (!o && !w) eop = 3'd5;
         else if (!o)     eop = 3'd2;
         else if (!w)     eop = 3'd3;
         else             eop = 3'd1;
         chk("R9 op code", bus_op, eop);
         if (eop == 3'd2)
            chk("R1 R2 read lanes", {dq_oe_lo, dq_oe_hi}, b ? 2'b11 : 2'b10);
         else
            chk("R6 R8 no drive", {dq_oe_lo, dq_oe_hi}, 2'b00);
         step();
         pins(1'b1, 1'b1, 1'b1, 1'b1);
      end
      // none of the single-cycle writes above may be left unflagged; restart clean
      step();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;

      // R8: clash held, then released: no strobe
      step();
      pins(1'b0, 1'b0, 1'b0, 1'b1);
      step();
      step();
      pins(1'b1, 1'b1, 1'b1, 1'b1);
      step(); #1;
      chk("R8 no strobe after clash", cmd_valid, 1'b0);
      step(); #1;
      chk("R8 no strobe after clash", cmd_valid, 1'b0);
      pins(1'b0, 1'b0, 1'b1, 1'b1); addr = 6'd9; #1;
      chk("R3 still array mode", dq_out, rom_word(9));

      // R4: word write, ended by we_n
      step();
      pins(1'b0, 1'b1, 1'b0, 1'b1); addr = 6'd5; dq_in = 16'hBEEF;
      step();
      we_n = 1'b1;
      #1;
      chk("R4 no strobe yet", cmd_valid, 1'b0);
      step(); #1;
      chk("R4 strobe", cmd_valid, 1'b1);
      chk("R4 word addr", cmd_addr, {6'd5, 1'b0});
      chk("R4 word data", cmd_data, 16'hBEEF);
      step(); #1;
      chk("R10 strobe ends", cmd_valid, 1'b0);

      // R5: reads now return command data
      pins(1'b0, 1'b0, 1'b1, 1'b1); addr = 6'd9; #1;
      chk("R5 word read", dq_out, 16'hBEEF);

      // R4: byte write, ended by ce_n
      step();
      pins(1'b0, 1'b1, 1'b0, 1'b0); addr = 6'd3; dq_in = 16'h803C;
      step();
      ce_n = 1'b1;
      step(); #1;
      chk("R4 byte strobe", cmd_valid, 1'b1);
      chk("R4 byte addr", cmd_addr, {6'd3, 1'b1});
      chk("R4 byte data", cmd_data, 16'h003C);
      step(); #1;
      chk("R10 byte strobe ends", cmd_valid, 1'b0);

      // R5: byte reads of command data
      pins(1'b0, 1'b0, 1'b1, 1'b0); dq_in = 16'h0000; #1;
      chk("R5 byte low", dq_out, 16'h003C);
      step();
      dq_in = 16'h8000; #1;
      chk("R5 byte high", dq_out, 16'h0000);

      // R3: reset restores array mode
      step();
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      pins(1'b0, 1'b0, 1'b1, 1'b1); addr = 6'd12; #1;
      chk("R3 array after reset", dq_out, rom_word(12));

      finish_run();
   end
endmodule